// File: doc/BRIEF.md
# Bus Transfer Modifier with Link

This block sits on the datapath between a selected source register and a selected destination register. Every register-to-register move passes through it. It takes a source word and a four-bit operation field. It can invert the word first. It then passes the word through, increments it, or rotates it by one place in either direction through a single link flip-flop. The modified word is delivered one clock later together with a valid strobe. The block also holds a byte-overflow flag, which records the carry out of an increment.

Two side channels share the flags. A control pulse can clear, set or toggle the link, and can also raise a halt request. A skip query tests the link and the overflow flag, or returns true unconditionally, and its answer can be inverted. A processor sequencer uses that answer to decide whether to step over the next instruction word.

Top module: `xfer_modifier`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid, out_data, link, ovf, halt_req, skip_valid and skip_hit are all zero.
- R2: out_valid is high exactly one clock after in_valid was sampled high, and at no other time. out_data changes only in that cycle and otherwise holds its last value.
- R3: When in_op bit 1 is 1, the source word is inverted before the selected function is applied. in_op bit 0 has no effect on any output.
- R4: in_op bits 3:2 = 00 delivers the (possibly inverted) word unchanged and leaves link and ovf unchanged.
- R5: in_op bits 3:2 = 01 delivers the word plus one modulo 2^DATA_W. It sets ovf when the increment carries out of the top bit and clears ovf otherwise. link is unchanged.
- R6: in_op bits 3:2 = 10 shifts the word left by one. The old link enters bit 0 and the old top bit becomes the new link. ovf is unchanged.
- R7: in_op bits 3:2 = 11 shifts the word right by one. The old link enters the top bit and the old bit 0 becomes the new link. ovf is unchanged.
- R8: A control pulse (ctl_valid) acts on ctl_code bits 1:0: 01 clears link, 10 sets it, 11 toggles it, and 00 leaves it alone. When a transfer is applied in the same cycle, the pulse acts on the link value that the transfer produces.
- R9: A control pulse with ctl_code bit 2 set drives halt_req high for exactly the next clock. Otherwise halt_req is low.
- R10: A skip query (qry_valid) drives skip_valid high for the next clock. skip_hit is then (qry_code[3] | qry_code[2]&link | qry_code[1]&ovf) XOR qry_code[0]. It is evaluated with the flag values held before that clock edge. With no query, skip_valid and skip_hit are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source word and operation are valid this cycle |
| in_data | input | DATA_W | Source word |
| in_op | input | 4 | Operation field: bit 1 invert, bits 3:2 function, bit 0 unused |
| ctl_valid | input | 1 | Link control pulse strobe |
| ctl_code | input | 3 | Bits 1:0 link action, bit 2 halt request |
| qry_valid | input | 1 | Skip query strobe |
| qry_code | input | 4 | Bit 3 always, bit 2 link, bit 1 overflow, bit 0 invert answer |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_data | output | DATA_W | Modified word |
| link | output | 1 | Link flip-flop |
| ovf | output | 1 | Byte-overflow flag |
| halt_req | output | 1 | One-clock halt request |
| skip_valid | output | 1 | Skip answer strobe |
| skip_hit | output | 1 | Skip answer |

## Verification
A wrong link value appears at the link port on the clock that follows the corrupting transfer or pulse. A wrong link also corrupts the first or last bit of the next rotate result, and the answer of the next skip query that tests the link. A wrong overflow flag appears at once on ovf, and again at the next query that tests it. A flag that is disturbed by a pass, or by a function that should not touch it, is therefore seen one clock later. The cycle-by-cycle comparison catches it in that same cycle, not when the value is next used.

// File: rtl/xfer_mod_pkg.sv
package xfer_mod_pkg;

   typedef enum logic [1:0] {
      FN_PASS = 2'b00,
      FN_INC  = 2'b01,
      FN_ROL  = 2'b10,
      FN_ROR  = 2'b11
   } xfer_fn_e;

   typedef struct packed {
      xfer_fn_e fn;
      logic     invert;
      logic     spare;
   } xfer_op_t;

   typedef enum logic [1:0] {
      LK_KEEP   = 2'b00,
      LK_CLEAR  = 2'b01,
      LK_SET    = 2'b10,
      LK_TOGGLE = 2'b11
   } link_act_e;

   function automatic xfer_op_t unpack_op(input logic [3:0] raw);
      xfer_op_t o;
      o.fn     = xfer_fn_e'(raw[3:2]);
      o.invert = raw[1];
      o.spare  = raw[0];
      return o;
   endfunction

   function automatic logic apply_link_act(input logic cur, input link_act_e act);
      logic r;
      case (act)
         LK_CLEAR:  r = 1'b0;
         LK_SET:    r = 1'b1;
         LK_TOGGLE: r = ~cur;
         default:   r = cur;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/xfm_datapath.sv
module xfm_datapath
   import xfer_mod_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] src,
   input  logic [3:0]        op_raw,
   input  logic              link_cur,
   output logic [DATA_W-1:0] res,
   output logic              link_nxt,
   output logic              link_we,
   output logic              ovf_nxt,
   output logic              ovf_we
);

   localparam int TOP = DATA_W - 1;

   xfer_op_t          op;
   logic [DATA_W-1:0] operand;
   logic [DATA_W-1:0] rol_v;
   logic [DATA_W-1:0] ror_v;
   logic [DATA_W:0]   inc_v;

   assign op      = unpack_op(op_raw);
   assign operand = op.invert ? ~src : src;
   assign inc_v   = {1'b0, operand} + {{DATA_W{1'b0}}, 1'b1};

   for (genvar i = 0; i < DATA_W; i++) begin : g_rot
      if (i == 0) begin : g_lsb
         assign rol_v[i] = link_cur;
         assign ror_v[i] = operand[i+1];
      end else if (i == TOP) begin : g_msb
         assign rol_v[i] = operand[i-1];
         assign ror_v[i] = link_cur;
      end else begin : g_mid
         assign rol_v[i] = operand[i-1];
         assign ror_v[i] = operand[i+1];
      end
   end

   always_comb begin
      res      = operand;
      link_nxt = link_cur;
      link_we  = 1'b0;
      ovf_nxt  = 1'b0;
      ovf_we   = 1'b0;
      case (op.fn)
         FN_INC: begin
            res     = inc_v[DATA_W-1:0];
            ovf_nxt = inc_v[DATA_W];
            ovf_we  = 1'b1;
         end
         FN_ROL: begin
            res      = rol_v;
            link_nxt = operand[TOP];
            link_we  = 1'b1;
         end
         FN_ROR: begin
            res      = ror_v;
            link_nxt = operand[0];
            link_we  = 1'b1;
         end
         default: res = operand;
      endcase
   end

endmodule

// File: rtl/xfm_flags.sv
module xfm_flags
   import xfer_mod_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       xfer_fire,
   input  logic       link_we,
   input  logic       link_nxt,
   input  logic       ovf_we,
   input  logic       ovf_nxt,
   input  logic       ctl_valid,
   input  logic [2:0] ctl_code,
   output logic       link_q,
   output logic       ovf_q,
   output logic       halt_q
);

   logic      link_mid;
   link_act_e act;

   assign act      = ctl_valid ? link_act_e'(ctl_code[1:0]) : LK_KEEP;
   assign link_mid = (xfer_fire && link_we) ? link_nxt : link_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         link_q <= 1'b0;
         ovf_q  <= 1'b0;
         halt_q <= 1'b0;
      end else begin
         link_q <= apply_link_act(link_mid, act);
         if (xfer_fire && ovf_we)
            ovf_q <= ovf_nxt;
         halt_q <= ctl_valid & ctl_code[2];
      end
   end

   // R8
   link_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_valid && ctl_code[1:0] == 2'b10) |=> link_q);
   // R8
   link_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_valid && ctl_code[1:0] == 2'b01) |=> !link_q);
   // R9
   halt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_valid && ctl_code[2]) |=> halt_q);
   // R5
   ovf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(xfer_fire && ovf_we) |=> $stable(ovf_q));

endmodule

// File: rtl/xfm_skip.sv
module xfm_skip (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       qry_valid,
   input  logic [3:0] qry_code,
   input  logic       link_q,
   input  logic       ovf_q,
   output logic       skip_valid,
   output logic       skip_hit
);

   logic cond;

   assign cond = qry_code[3] | (qry_code[2] & link_q) | (qry_code[1] & ovf_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         skip_valid <= 1'b0;
         skip_hit   <= 1'b0;
      end else begin
         skip_valid <= qry_valid;
         skip_hit   <= qry_valid & (cond ^ qry_code[0]);
      end
   end

   // R10
   skip_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_valid && qry_code[3]) |=> (skip_valid && skip_hit == !$past(qry_code[0])));
   // R10
   skip_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !qry_valid |=> (!skip_valid && !skip_hit));

endmodule

// File: rtl/xfer_modifier.sv
module xfer_modifier
   import xfer_mod_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [3:0]        in_op,
   input  logic              ctl_valid,
   input  logic [2:0]        ctl_code,
   input  logic              qry_valid,
   input  logic [3:0]        qry_code,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              link,
   output logic              ovf,
   output logic              halt_req,
   output logic              skip_valid,
   output logic              skip_hit
);

   if (DATA_W < 2) begin : g_bad_width
      $error("xfer_modifier: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] res;
   logic              link_nxt, link_we, ovf_nxt, ovf_we;

   xfm_datapath #(.DATA_W(DATA_W)) u_dp (
      .src      (in_data),
      .op_raw   (in_op),
      .link_cur (link),
      .res      (res),
      .link_nxt (link_nxt),
      .link_we  (link_we),
      .ovf_nxt  (ovf_nxt),
      .ovf_we   (ovf_we)
   );

   xfm_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .xfer_fire (in_valid),
      .link_we   (link_we),
      .link_nxt  (link_nxt),
      .ovf_we    (ovf_we),
      .ovf_nxt   (ovf_nxt),
      .ctl_valid (ctl_valid),
      .ctl_code  (ctl_code),
      .link_q    (link),
      .ovf_q     (ovf),
      .halt_q    (halt_req)
   );

   xfm_skip u_skip (
      .clk        (clk),
      .rst_n      (rst_n),
      .qry_valid  (qry_valid),
      .qry_code   (qry_code),
      .link_q     (link),
      .ovf_q      (ovf),
      .skip_valid (skip_valid),
      .skip_hit   (skip_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_data <= res;
      end
   end

   // R2
   out_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R2
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_data)));
   // R4
   pass_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op[3:2] == 2'b00 && !ctl_valid) |=> ($stable(link) && $stable(ovf)));
   // R5
   inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op[3:1] == 3'b010 && in_data == {DATA_W{1'b1}}) |=>
      (ovf && out_data == '0));

endmodule

// File: tb/xfer_modifier_bench.sv
module xfer_modifier_bench;

   localparam int W    = 16;
   localparam int MASK = 32'h0000FFFF;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic [3:0]   in_op = '0;
   logic         ctl_valid = 1'b0;
   logic [2:0]   ctl_code = '0;
   logic         qry_valid = 1'b0;
   logic [3:0]   qry_code = '0;
   logic         out_valid, link, ovf, halt_req, skip_valid, skip_hit;
   logic [W-1:0] out_data;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   int m_link = 0, m_ovf = 0, m_data = 0;
   int e_valid = 0, e_halt = 0, e_sv = 0, e_sh = 0;
   string t_data = "R2", t_link = "R4", t_ovf = "R4";

   xfer_modifier #(.DATA_W(W)) u_xfer_modifier (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_op(in_op),
      .ctl_valid(ctl_valid), .ctl_code(ctl_code), .qry_valid(qry_valid), .qry_code(qry_code),
      .out_valid(out_valid), .out_data(out_data), .link(link), .ovf(ovf),
      .halt_req(halt_req), .skip_valid(skip_valid), .skip_hit(skip_hit)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R2", "out_valid", int'(out_valid), e_valid);
      chk(t_data, "out_data", int'(out_data), m_data);
      chk(t_link, "link", int'(link), m_link);
      chk(t_ovf, "ovf", int'(ovf), m_ovf);
      chk("R9", "halt_req", int'(halt_req), e_halt);
      chk("R10", "skip_valid", int'(skip_valid), e_sv);
      chk("R10", "skip_hit", int'(skip_hit), e_sh);
   endtask

   // one clock: check outputs, drive new inputs, predict next outputs
   task automatic step(input bit iv, input int d, input int op,
                       input bit cv, input int cc, input bit qv, input int qc);
      int v;
      @(negedge clk);
      compare_all();
      in_valid = iv; in_data = d[W-1:0]; in_op = op[3:0];
      ctl_valid = cv; ctl_code = cc[2:0]; qry_valid = qv; qry_code = qc[3:0];
      e_sv = qv;
      e_sh = qv ? ((((qc >> 3) & 1) | (((qc >> 2) & 1) & m_link) | (((qc >> 1) & 1) & m_ovf))
                   ^ (qc & 1)) : 0;
      e_valid = iv;
      e_halt  = (cv && ((cc >> 2) & 1)) ? 1 : 0;
      t_link = "R4"; t_ovf = "R4"; t_data = "R2";
      if (iv) begin
         v = ((op >> 1) & 1) ? (~d & MASK) : (d & MASK);
         t_data = ((op >> 1) & 1) ? "R3" : "R4";
         case ((op >> 2) & 3)
            1: begin
               m_ovf = (v == MASK) ? 1 : 0;
               m_data = (v + 1) & MASK;
               t_data = "R5"; t_ovf = "R5"; t_link = "R5";
            end
            2: begin
               m_data = ((v << 1) | m_link) & MASK;
               m_link = (v >> (W - 1)) & 1;
               t_data = "R6"; t_link = "R6"; t_ovf = "R6";
            end
            3: begin
               m_data = (v >> 1) | (m_link << (W - 1));
               m_link = v & 1;
               t_data = "R7"; t_link = "R7"; t_ovf = "R7";
            end
            default: m_data = v;
         endcase
      end
      if (cv && (cc & 3) != 0) begin
         t_link = "R8";
         case (cc & 3)
            1: m_link = 0;
            2: m_link = 1;
            default: m_link = m_link ^ 1;
         endcase
      end
   endtask

   initial begin : watchdog
      while (cycles < 100000) begin
         @(posedge clk);
         cycles++;
      end
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      t_data = "R1"; t_link = "R1"; t_ovf = "R1";
      compare_all();                                  // R1 during reset
      rst_n = 1'b1;
      step(0, 0, 0, 0, 0, 0, 0);                      // R1 after release
      step(1, 16'h1234, 4'b0000, 0, 0, 0, 0);         // R4 pass
      step(1, 16'h1234, 4'b0010, 0, 0, 0, 0);         // R3 invert pass
      step(1, 16'h1234, 4'b0011, 0, 0, 0, 0);         // R3 spare bit ignored
      step(0, 16'hAAAA, 4'b0100, 0, 0, 0, 0);         // R2 no strobe, hold
      step(1, 16'hFFFF, 4'b0100, 0, 0, 0, 0);         // R5 carry out
      step(1, 16'h0000, 4'b0000, 0, 0, 1, 4'b0010);   // R4 keeps ovf, R10 ovf test
      step(1, 16'h0001, 4'b0100, 0, 0, 0, 0);         // R5 clears ovf
      step(1, 16'h0000, 4'b0110, 0, 0, 0, 0);         // R3 R5 invert then inc wraps
      step(1, 16'h8000, 4'b1000, 0, 0, 0, 0);         // R6 top bit into link
      step(1, 16'h0000, 4'b1000, 0, 0, 1, 4'b0100);   // R6 link into bit 0, R10
      step(1, 16'h0001, 4'b1100, 0, 0, 0, 0);         // R7
      step(1, 16'h0000, 4'b1100, 0, 0, 0, 0);         // R7 link into top
      step(0, 0, 0, 1, 3'b010, 0, 0);                 // R8 set
      step(0, 0, 0, 1, 3'b011, 0, 0);                 // R8 toggle
      step(0, 0, 0, 1, 3'b001, 1, 4'b0101);           // R8 clear, R10 inverted
      step(0, 0, 0, 1, 3'b100, 1, 4'b1000);           // R9 halt, R8 keep, R10 always
      step(1, 16'h8000, 4'b1000, 1, 3'b011, 1, 4'b1001); // R8 after rotate
      step(0, 0, 0, 0, 0, 1, 4'b0000);                // R10 nothing tested
      for (int i = 0; i < 3000; i++) begin
         step(1'($urandom_range(0, 1)), int'($urandom_range(0, MASK)), int'($urandom_range(0, 15)),
              1'($urandom_range(0, 3) == 0), int'($urandom_range(0, 7)),
              1'($urandom_range(0, 1)), int'($urandom_range(0, 15)));
      end
      step(0, 0, 0, 0, 0, 0, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule